// File: doc/BRIEF.md
# On-time/period PWM stage

This block produces a pulse-width modulated level from two 8-bit values: a high time and a cycle-length value. It contains a small counter that steps only on cycles where an external rate tick is asserted, so the PWM rate is set by whatever divider produces the tick rather than by the core clock. A full PWM cycle spans `period_i + 1` ticks, and the output stays high for the first `on_i` ticks of each cycle.

The high-time and cycle-length inputs pass through a shadow register. Values presented in the middle of a cycle wait until the counter returns to zero, so a cycle is never cut short or stretched partway through. While the run input is low, the counter stays at zero, the output stays low, and the shadow register follows the inputs. When run is raised, the first cycle therefore uses the values present just before the start. An on value larger than the cycle-length value gives a steady high level. On = 0xFF with period = 0xFE is the usual way to program 100% duty. On = 0 gives a steady low level.

Top module: `pwm_ontime`

## Requirements
- R1: While `rst_ni` is low, and after it is released with `run_i` low, `pwm_o` is 0.
- R2: The counter advances only on clock edges where `tick_i` is 1. If `tick_i` is 0, `pwm_o` keeps its value.
- R3: A running cycle lasts `period + 1` ticks. The count goes 0, 1, …, period and then returns to 0.
- R4: While running, `pwm_o` is 1 when the count is below the latched on value and 0 otherwise. Each cycle therefore has min(on, period+1) high ticks.
- R5: If the latched on value is greater than the latched period, `pwm_o` is a constant 1 with no low pulse. This includes on = 0xFF with period = 0xFE.
- R6: A latched on value of 0 gives a constant 0 output.
- R7: New values on `on_i`/`period_i` are captured only when the count wraps to 0, or while `run_i` is low. A change made mid-cycle does not affect the current cycle.
- R8: One clock after `run_i` is sampled low, the count is 0 and `pwm_o` is 0.
- R9: One clock after `run_i` is sampled high following a stop, the output starts a cycle at count 0, using the values present on the last clock with `run_i` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run enable; low stops and clears the counter |
| tick_i | input | 1 | Rate tick from the frequency generator; one count step per asserted cycle |
| on_i | input | 8 | High time, in ticks |
| period_i | input | 8 | Cycle length minus one, in ticks |
| pwm_o | output | 1 | PWM level |

## Verification
Directed patterns check the duty extremes. On above period (0xFF/0xFE) must never show a low sample, and on = 0 must never show a high sample. A 3-of-10 setting with a tick every cycle must give exactly 30% high samples, which confirms both the cycle length and the compare point. Sparse ticks show that only tick cycles move the waveform, and edits made mid-cycle show that shadowing holds the current cycle. Random runs vary the tick density, the values, and run drops, and every sample is compared against a cycle model written in the bench.

// File: rtl/pwm_ontime_pkg.sv
package pwm_ontime_pkg;
  parameter int unsigned PWM_W = 8;
  typedef logic [PWM_W-1:0] pwm_val_t;
  typedef struct packed {
    pwm_val_t on;
    pwm_val_t per;
  } pwm_cfg_t;
endpackage

// File: rtl/pwm_ontime_shadow.sv
module pwm_ontime_shadow
  import pwm_ontime_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  pwm_cfg_t cfg_i,
  output pwm_cfg_t cfg_o
);
  pwm_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (load_i) cfg_q <= cfg_i;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/pwm_ontime_counter.sv
module pwm_ontime_counter
  import pwm_ontime_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  logic     tick_i,
  input  pwm_val_t per_i,
  output pwm_val_t cnt_o,
  output logic     active_o,
  output logic     wrap_o
);
  pwm_val_t cnt_q;
  logic     active_q;
  logic     step;
  logic     at_end;

  assign step   = run_i & active_q & tick_i;
  // >= keeps a stray count above period from running off
  assign at_end = (cnt_q >= per_i);
  assign wrap_o = step & at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      active_q <= 1'b1;
      if (step) cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign active_o = active_q;
endmodule

// File: rtl/pwm_ontime_compare.sv
module pwm_ontime_compare
  import pwm_ontime_pkg::*;
(
  input  logic     active_i,
  input  pwm_val_t cnt_i,
  input  pwm_val_t on_i,
  output logic     pwm_o
);
  assign pwm_o = active_i & (cnt_i < on_i);
endmodule

// File: rtl/pwm_ontime.sv
module pwm_ontime
  import pwm_ontime_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [PWM_W-1:0] on_i,
  input  logic [PWM_W-1:0] period_i,
  output logic             pwm_o
);
  pwm_cfg_t cfg_in, cfg_q;
  pwm_val_t cnt;
  logic     active, wrap, load;

  assign cfg_in.on  = on_i;
  assign cfg_in.per = period_i;
  assign load       = ~run_i | wrap;

  pwm_ontime_shadow u_shadow (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .cfg_i (cfg_in),
    .cfg_o (cfg_q)
  );

  pwm_ontime_counter u_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .tick_i  (tick_i),
    .per_i   (cfg_q.per),
    .cnt_o   (cnt),
    .active_o(active),
    .wrap_o  (wrap)
  );

  pwm_ontime_compare u_compare (
    .active_i(active),
    .cnt_i   (cnt),
    .on_i    (cfg_q.on),
    .pwm_o   (pwm_o)
  );
endmodule

// File: rtl/pwm_ontime_checker.sv
module pwm_ontime_checker
  import pwm_ontime_pkg::*;
(
  input logic     clk_i,
  input logic     rst_ni,
  input logic     run_i,
  input logic     tick_i,
  input logic     pwm_o,
  input pwm_val_t cnt,
  input logic     active,
  input pwm_cfg_t cfg_q
);
  AST_RESET_LOW: assert property (@(posedge clk_i) !rst_ni |-> !pwm_o); // R1
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && active && !tick_i) |=> ($stable(cnt) && $stable(pwm_o))); // R2
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |-> (cnt <= cfg_q.per)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && active && tick_i && cnt == cfg_q.per) |=> (cnt == '0)); // R3
  AST_FULL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && cfg_q.on > cfg_q.per) |-> pwm_o); // R5
  AST_ZERO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.on == '0) |-> !pwm_o); // R6
  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !(active && tick_i && cnt == cfg_q.per)) |=> $stable(cfg_q)); // R7
  AST_STOP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt == '0 && !pwm_o)); // R8
  AST_START_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !active) |=> (active && cnt == '0)); // R9
endmodule

bind pwm_ontime pwm_ontime_checker u_checker (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .run_i (run_i),
  .tick_i(tick_i),
  .pwm_o (pwm_o),
  .cnt   (cnt),
  .active(active),
  .cfg_q (cfg_q)
);

// File: tb/pwm_ontime_bench.sv
module pwm_ontime_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] on_v = 8'd0;
  logic [7:0] per_v = 8'd0;
  logic       pwm;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m_cnt, m_on, m_per;
  logic       m_act;

  always #10 clk = ~clk;

  pwm_ontime u_pwm_ontime (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .tick_i(tick),
    .on_i(on_v), .period_i(per_v), .pwm_o(pwm)
  );

  // Cycle model built from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_on <= 0; m_per <= 0; m_act <= 0;
    end else if (!run) begin
      m_cnt <= 0; m_act <= 0; m_on <= on_v; m_per <= per_v;
    end else begin
      m_act <= 1;
      if (m_act && tick) begin
        if (m_cnt >= m_per) begin
          m_cnt <= 0; m_on <= on_v; m_per <= per_v;
        end else m_cnt <= m_cnt + 8'd1;
      end
    end
  end

  function automatic logic exp_pwm();
    return m_act && (m_cnt < m_on);
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0b expected=%0b", req, $time, act, exp);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Wait for a falling edge, compare against the model, return the sample
  task automatic cyc(string req, output logic s);
    @(negedge clk);
    check(req, pwm, exp_pwm());
    s = pwm;
  endtask

  task automatic stop_set(logic [7:0] o, logic [7:0] p);
    logic s;
    run = 0; on_v = o; per_v = p;
    cyc("R8", s);
    cyc("R8", s);
  endtask

  initial begin
    logic s;
    int hi, lo;
    logic prev;
    void'($urandom(32'd20240611));

    #5;
    check("R1", pwm, 1'b0);
    repeat (3) @(negedge clk);
    check("R1", pwm, 1'b0);
    rst_n = 1;
    cyc("R1", s);
    check("R1", s, 1'b0);

    // R5: 0xFF over 0xFE is steady high
    stop_set(8'hFF, 8'hFE);
    run = 1; tick = 1;
    cyc("R9", s);
    lo = 0;
    for (int i = 0; i < 600; i++) begin cyc("R5", s); if (!s) lo++; end
    check_int("R5 low samples", lo, 0);

    // R6: on = 0 is steady low
    stop_set(8'd0, 8'd5);
    run = 1;
    hi = 0;
    for (int i = 0; i < 100; i++) begin cyc("R6", s); if (s) hi++; end
    check_int("R6 high samples", hi, 0);

    // R3/R4: 3 of 10 ticks high
    stop_set(8'd3, 8'd9);
    run = 1;
    cyc("R9", s);
    check("R9 first sample high", s, 1'b1);
    hi = 0;
    for (int i = 0; i < 99; i++) begin cyc("R4", s); if (s) hi++; end
    hi += 1;
    check_int("R3 R4 high samples per 100", hi, 30);

    // R2: no ticks, output frozen
    tick = 0;
    cyc("R2", prev);
    for (int i = 0; i < 20; i++) begin cyc("R2", s); check("R2 stable", s, prev); end
    for (int i = 0; i < 60; i++) begin tick = (i % 3 == 0); cyc("R2", s); end

    // R7: mid-cycle edit waits for the wrap
    stop_set(8'd2, 8'd7);
    run = 1; tick = 1;
    cyc("R9", s);
    on_v = 8'd7;
    cyc("R7", s); check("R7 old on kept", s, 1'b1);
    cyc("R7", s); check("R7 old on kept", s, 1'b0);
    for (int i = 0; i < 30; i++) cyc("R7", s);

    // R8: drop run mid-cycle
    run = 0;
    cyc("R8", s); check("R8 low after stop", s, 1'b0);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      tick = ($urandom % 4) != 0;
      if ($urandom % 50 == 0) on_v = 8'($urandom);
      if ($urandom % 50 == 0) per_v = 8'($urandom % 24);
      if ($urandom % 300 == 0) run = 0;
      else if (!run && ($urandom % 4 == 0)) run = 1;
      cyc("R4 R7 random", s);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule